// File: doc/BRIEF.md
# Absolute Tape Record Loader

This block takes a byte stream through a valid/ready handshake and splits it into records. Each record opens with a six-byte header that holds a length and a load address. The payload bytes follow the header, and one checksum byte closes the record. Each payload byte goes to memory through a word-wide port with byte-lane enables. The bytes land at consecutive byte addresses, starting at the load address given in the header.

The block keeps a running mod-256 sum over every byte of the record, including the header and the checksum byte. If the sum at the end of a record is not zero, the block raises a sticky error flag and stops accepting input. A record with a length of zero is the end record. It finishes the load and raises a one-cycle done pulse. When the end record's address is even, the block also presents that address as a start address for the processor. After done or error, the block accepts no more bytes until it is reset.

Top module: `tape_loader`

## Requirements
- R1: After a synchronous active-high reset, in_ready is 1 and mem_we, done, error and start_valid are all 0.
- R2: The header is six bytes in this order: sync byte 0, sync byte 1, length low, length high, address low, address high. Sync byte values are not checked. All six header bytes count toward the checksum. No memory write happens while the header is being received.
- R3: Each accepted payload byte produces exactly one write, with mem_we high in the cycle after the byte is accepted. The byte address starts at the load address and rises by one per byte, wrapping modulo 2^16. mem_addr is the byte address shifted right by one. mem_be is 2'b01 for an even byte address and 2'b10 for an odd one. mem_wdata carries the byte on both lanes.
- R4: The checksum holds when the mod-256 sum of all record bytes, including the checksum byte, is zero. If it does not hold, error goes high in the cycle after the checksum byte is accepted.
- R5: Once error is high, it stays high, in_ready stays 0, and no further memory write happens.
- R6: A record with a length of zero ends the load. If its checksum holds, done is high for exactly one cycle, in the cycle after the checksum byte is accepted. From then on, in_ready stays 0.
- R7: On a good end record whose address has bit 0 clear, start_valid goes high together with done, and start_addr equals the record's address.
- R8: On a good end record whose address has bit 0 set, start_valid stays 0.
- R9: Records of non-zero length are processed back to back, with no gap. The 16-bit length allows payloads longer than 255 bytes. A record of non-zero length never raises done.
- R10: An end record with a failing checksum raises error. It raises neither done nor start_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block can accept a byte |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 15 | Memory word address |
| mem_be | output | 2 | Byte-lane enables |
| mem_wdata | output | 16 | Write data, byte replicated on both lanes |
| done | output | 1 | One-cycle pulse after a good end record |
| error | output | 1 | Sticky checksum error |
| start_valid | output | 1 | Start address is present |
| start_addr | output | 16 | Even start address from the end record |

## Verification
The assertions assume that in_valid and in_data change only away from the clock edge. They also assume that reset is held for at least one edge before the first byte, so the sticky flags and the done pulse begin from a known state. The bench drives bytes at the falling edge and keeps each byte for a single rising edge. After done or error it presents bytes only to confirm that they are refused. It builds every checksum itself from the record contents, so a bad record is always made on purpose.

// File: rtl/tape_ld_pkg.sv
package tape_ld_pkg;
    localparam int FIELD_W   = 16;
    localparam int HDR_BYTES = 6;
    localparam int HCNT_W    = $clog2(HDR_BYTES);

    typedef enum logic [2:0] {
        ST_HDR,
        ST_PAY,
        ST_SUM,
        ST_FIN,
        ST_ERR
    } ld_state_e;

    typedef struct packed {
        logic [FIELD_W-1:0] len;
        logic [FIELD_W-1:0] addr;
    } rec_hdr_t;

    function automatic logic [7:0] sum8(input logic [7:0] a, input logic [7:0] b);
        return a + b;
    endfunction
endpackage

// File: rtl/tape_ld_csum.sv
module tape_ld_csum (
    input  logic       clk,
    input  logic       rst,
    input  logic       take,
    input  logic       last,
    input  logic [7:0] byte_in,
    output logic       zero_next
);
    import tape_ld_pkg::*;
    logic [7:0] acc_q;

    assign zero_next = (sum8(acc_q, byte_in) == 8'h00);

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (take)
            acc_q <= last ? 8'h00 : sum8(acc_q, byte_in);
    end
endmodule

// File: rtl/tape_ld_mwr.sv
module tape_ld_mwr #(
    parameter int DATA_W = 16
) (
    input  logic                                         clk,
    input  logic                                         rst,
    input  logic                                         wr,
    input  logic [tape_ld_pkg::FIELD_W-1:0]              baddr,
    input  logic [7:0]                                   byte_in,
    output logic                                         mem_we,
    output logic [tape_ld_pkg::FIELD_W-$clog2(DATA_W/8)-1:0] mem_addr,
    output logic [DATA_W/8-1:0]                          mem_be,
    output logic [DATA_W-1:0]                            mem_wdata
);
    import tape_ld_pkg::*;
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);

    logic [LANES-1:0] be_n;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign be_n[g] = (baddr[LANE_W-1:0] == LANE_W'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_be    <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= wr;
            if (wr) begin
                mem_addr  <= baddr[FIELD_W-1:LANE_W];
                mem_be    <= be_n;
                mem_wdata <= {LANES{byte_in}};
            end
        end
    end
endmodule

// File: rtl/tape_ld_parse.sv
module tape_ld_parse (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            in_valid,
    input  logic [7:0]                      in_data,
    input  logic                            sum_ok,
    output logic                            in_ready,
    output logic                            take,
    output logic                            rec_last,
    output logic                            wr,
    output logic [tape_ld_pkg::FIELD_W-1:0] wr_addr,
    output logic                            done,
    output logic                            error,
    output logic                            start_valid,
    output logic [tape_ld_pkg::FIELD_W-1:0] start_addr
);
    import tape_ld_pkg::*;

    ld_state_e          st_q;
    logic [HCNT_W-1:0]  hcnt_q;
    rec_hdr_t           hdr_q;
    logic [FIELD_W-1:0] rem_q;
    logic [FIELD_W-1:0] len_full;

    assign in_ready = (st_q == ST_HDR) || (st_q == ST_PAY) || (st_q == ST_SUM);
    assign take     = in_valid && in_ready;
    assign rec_last = (st_q == ST_SUM);
    assign wr       = take && (st_q == ST_PAY);
    assign wr_addr  = hdr_q.addr;
    assign len_full = {hdr_q.len[FIELD_W-1:8], hdr_q.len[7:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_HDR;
            hcnt_q      <= '0;
            hdr_q       <= '0;
            rem_q       <= '0;
            done        <= 1'b0;
            error       <= 1'b0;
            start_valid <= 1'b0;
            start_addr  <= '0;
        end else begin
            done <= 1'b0;
            if (take) begin
                unique case (st_q)
                    ST_HDR: begin
                        hcnt_q <= hcnt_q + 1'b1;
                        case (hcnt_q)
                            HCNT_W'(2): hdr_q.len[7:0]           <= in_data;
                            HCNT_W'(3): hdr_q.len[FIELD_W-1:8]   <= in_data;
                            HCNT_W'(4): hdr_q.addr[7:0]          <= in_data;
                            HCNT_W'(5): begin
                                hdr_q.addr[FIELD_W-1:8] <= in_data;
                                hcnt_q <= '0;
                                rem_q  <= len_full;
                                st_q   <= (len_full == '0) ? ST_SUM : ST_PAY;
                            end
                            default: ;
                        endcase
                    end
                    ST_PAY: begin
                        hdr_q.addr <= hdr_q.addr + 1'b1;
                        rem_q      <= rem_q - 1'b1;
                        if (rem_q == FIELD_W'(1))
                            st_q <= ST_SUM;
                    end
                    ST_SUM: begin
                        if (!sum_ok) begin
                            st_q  <= ST_ERR;
                            error <= 1'b1;
                        end else if (hdr_q.len == '0) begin
                            st_q <= ST_FIN;
                            done <= 1'b1;
                            if (!hdr_q.addr[0]) begin
                                start_valid <= 1'b1;
                                start_addr  <= hdr_q.addr;
                            end
                        end else begin
                            st_q <= ST_HDR;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/tape_loader.sv
module tape_loader #(
    parameter int DATA_W = 16
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic                                      in_valid,
    input  logic [7:0]                                in_data,
    output logic                                      in_ready,
    output logic                                      mem_we,
    output logic [tape_ld_pkg::FIELD_W-$clog2(DATA_W/8)-1:0] mem_addr,
    output logic [DATA_W/8-1:0]                       mem_be,
    output logic [DATA_W-1:0]                         mem_wdata,
    output logic                                      done,
    output logic                                      error,
    output logic                                      start_valid,
    output logic [tape_ld_pkg::FIELD_W-1:0]           start_addr
);
    import tape_ld_pkg::*;

    logic               take;
    logic               rec_last;
    logic               sum_ok;
    logic               wr;
    logic [FIELD_W-1:0] wr_addr;

    tape_ld_parse u_parse (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .sum_ok      (sum_ok),
        .in_ready    (in_ready),
        .take        (take),
        .rec_last    (rec_last),
        .wr          (wr),
        .wr_addr     (wr_addr),
        .done        (done),
        .error       (error),
        .start_valid (start_valid),
        .start_addr  (start_addr)
    );

    tape_ld_csum u_csum (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .last      (rec_last),
        .byte_in   (in_data),
        .zero_next (sum_ok)
    );

    tape_ld_mwr #(.DATA_W(DATA_W)) u_mwr (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .baddr     (wr_addr),
        .byte_in   (in_data),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata)
    );
endmodule

// File: rtl/tape_loader_chk.sv
module tape_loader_chk #(
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             in_ready,
    input logic             mem_we,
    input logic [LANES-1:0] mem_be,
    input logic             done,
    input logic             error,
    input logic             start_valid,
    input logic [15:0]      start_addr
);
    p_one_lane_r3: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $countones(mem_be) == 1);
    p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        error |=> error);
    p_err_blocks_r5: assert property (@(posedge clk) disable iff (rst)
        error |-> (!in_ready && !mem_we));
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> !in_ready);
    p_start_even_r7: assert property (@(posedge clk) disable iff (rst)
        start_valid |-> !start_addr[0]);
    p_start_with_done_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(start_valid) |-> done);
    p_no_done_on_err_r10: assert property (@(posedge clk) disable iff (rst)
        !(done && error));
endmodule

bind tape_loader tape_loader_chk #(.LANES(DATA_W/8)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_ready    (in_ready),
    .mem_we      (mem_we),
    .mem_be      (mem_be),
    .done        (done),
    .error       (error),
    .start_valid (start_valid),
    .start_addr  (start_addr)
);

// File: tb/sim_tape_loader.sv
module sim_tape_loader;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready;
    logic        mem_we;
    logic [14:0] mem_addr;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata;
    logic        done;
    logic        error;
    logic        start_valid;
    logic [15:0] start_addr;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    tape_loader u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .done(done), .error(error),
        .start_valid(start_valid), .start_addr(start_addr)
    );

    // {address, length, first payload byte}
    localparam logic [39:0] RECS [4] = '{
        {16'h1000, 16'h0003, 8'h10},
        {16'h2001, 16'h0004, 8'hA0},
        {16'hFFFF, 16'h0002, 8'h55},
        {16'h4000, 16'h0102, 8'h33}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // starts and ends at a falling edge
    task automatic put(input logic [7:0] b);
        chk(in_ready, "R9 ready before byte", {31'b0, in_ready}, 32'd1);
        in_valid = 1'b1;
        in_data  = b;
        @(posedge clk);
        #1 in_valid = 1'b0;
        @(negedge clk);
    endtask

    // mode 0 good, 1 checksum flipped, 2 checksum omits header
    task automatic send_record(input logic [15:0] a, input logic [15:0] n,
                               input logic [7:0] seed, input int mode);
        logic [7:0] hs;
        logic [7:0] ps;
        logic [7:0] cs;
        logic [7:0] h [6];
        logic [15:0] ba;
        logic [7:0] b;
        hs = 8'h00;
        ps = 8'h00;
        h[0] = 8'h01; h[1] = 8'h00; h[2] = n[7:0]; h[3] = n[15:8];
        h[4] = a[7:0]; h[5] = a[15:8];
        for (int k = 0; k < 6; k++) begin
            put(h[k]);
            hs = hs + h[k];
            chk(!mem_we, "R2 no write in header", {31'b0, mem_we}, 32'd0);
        end
        for (int i = 0; i < int'(n); i++) begin
            b  = seed + 8'(i);
            ba = a + 16'(i);
            put(b);
            ps = ps + b;
            chk(mem_we, "R3 write strobe", {31'b0, mem_we}, 32'd1);
            chk(mem_addr == ba[15:1], "R3 word address", {17'b0, mem_addr}, {17'b0, ba[15:1]});
            chk(mem_be == (ba[0] ? 2'b10 : 2'b01), "R3 lane enable", {30'b0, mem_be},
                {30'b0, (ba[0] ? 2'b10 : 2'b01)});
            chk(mem_wdata == {b, b}, "R3 write data", {16'b0, mem_wdata}, {16'b0, b, b});
        end
        cs = (mode == 2) ? (8'h00 - ps) : (8'h00 - hs - ps);
        if (mode == 1) cs = cs ^ 8'h01;
        put(cs);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(in_ready == 1'b1, "R1 in_ready", {31'b0, in_ready}, 32'd1);
        chk({mem_we, done, error, start_valid} == 4'b0, "R1 outputs idle",
            {28'b0, mem_we, done, error, start_valid}, 32'd0);

        // table walk: R2, R3, R9
        for (int r = 0; r < 4; r++) begin
            send_record(RECS[r][39:24], RECS[r][23:8], RECS[r][7:0], 0);
            chk(!done && !error, "R9 no done on data record",
                {30'b0, done, error}, 32'd0);
        end

        // R6, R7 even end record
        send_record(16'h0200, 16'h0000, 8'h00, 0);
        chk(done, "R6 done pulse", {31'b0, done}, 32'd1);
        chk(start_valid, "R7 start valid", {31'b0, start_valid}, 32'd1);
        chk(start_addr == 16'h0200, "R7 start address", {16'b0, start_addr}, 32'h0200);
        @(negedge clk);
        chk(!done, "R6 done one cycle", {31'b0, done}, 32'd0);
        chk(!in_ready, "R6 ready low after end", {31'b0, in_ready}, 32'd0);

        // R8 odd end record
        do_reset();
        send_record(16'h0301, 16'h0000, 8'h00, 0);
        chk(done, "R8 done on odd end", {31'b0, done}, 32'd1);
        chk(!start_valid, "R8 no start on odd end", {31'b0, start_valid}, 32'd0);

        // R4, R5 bad payload checksum
        do_reset();
        send_record(16'h1234, 16'h0002, 8'h77, 1);
        chk(error, "R4 error on bad sum", {31'b0, error}, 32'd1);
        chk(!done, "R4 no done on bad sum", {31'b0, done}, 32'd0);
        in_valid = 1'b1;
        in_data  = 8'hAA;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!mem_we && !in_ready && error, "R5 input refused after error",
                {29'b0, mem_we, in_ready, error}, 32'd1);
        end
        in_valid = 1'b0;

        // R2 header bytes are part of the sum
        do_reset();
        send_record(16'h0500, 16'h0001, 8'h11, 2);
        chk(error, "R2 header counted in sum", {31'b0, error}, 32'd1);

        // R10 bad end record
        do_reset();
        send_record(16'h0600, 16'h0000, 8'h00, 1);
        chk(error && !done && !start_valid, "R10 bad end record",
            {29'b0, error, done, start_valid}, 32'h4);

        // R1 reset again clears flags
        do_reset();
        chk(in_ready && !error && !start_valid, "R1 after reset",
            {29'b0, in_ready, error, start_valid}, 32'h4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule